// File: doc/BRIEF.md
# Key-Protected Pixel Clock Parameter Registers

This block is a small register group on the sequencer side of a display controller. It stores the multiplier and divider fields for two frequency synthesizers, one for memory and one for video, plus a command byte. All of its extended index space sits behind a one-byte key register. Software selects a register by index and then writes or reads a data byte. Until the key register holds the opening value, every extended write is dropped. An extended read then returns a placeholder that depends only on the index.

The block also reports the active pixel clock in kHz. Two clock-select bits come from the controller's miscellaneous output register. They choose between two fixed oscillator rates and the programmable video synthesizer. The synthesizer rate is the 14318 kHz reference times (M+2), divided by (N+2) and by 2 to the power R, using integer arithmetic. A bit in the command byte halves whichever rate is selected. The synthesizer fields are also driven out as ports for the clock generator.

Top module: `pxclk_cfg`

## Requirements
- R1: After reset, the key register, both synthesizer parameter sets and the command byte read as zero.
- R2: A write to any index above 0x08 has no effect unless the key register holds 0x06. Relocking with another key value blocks such writes again.
- R3: While the key is not 0x06, a read of an index above 0x08 returns 0x00 for indexes below 0x1B. For indexes of 0x1B and above, it returns the index value itself.
- R4: Index 0x08 is the key register. It accepts writes and returns its full byte whatever the lock state.
- R5: Index 0x10 (memory) and index 0x12 (video) each hold N in data bits 4:0 and R in data bits 7:5. A read returns {R, N}, and the fields appear on the matching output ports.
- R6: Index 0x11 (memory) and index 0x13 (video) each hold M in data bits 6:0. Data bit 7 is discarded, so a read returns {1'b0, M}.
- R7: Index 0x15 holds an 8-bit command byte that reads back unchanged.
- R8: Clock select 0 reports 25175 kHz and clock select 1 reports 28322 kHz.
- R9: Clock select 2 or 3 reports floor(14318*(M+2) / ((N+2)*2^R)) kHz, using the video synthesizer fields.
- R10: When bit 4 of the command byte is set, the reported value is the selected rate divided by two, rounded down. This holds for every clock select.
- R11: While unlocked, a read of any index that holds no register returns 0x00. This includes indexes below 0x08 and indexes of 0x1B and above.
- R12: Read data and rd_valid appear one clock after rd_en. pix_khz reflects its inputs one clock after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for idx/wdata |
| rd_en | input | 1 | Read strobe for idx |
| idx | input | 8 | Register index |
| wdata | input | 8 | Write data |
| clk_sel | input | 2 | Clock-select bits from the miscellaneous output register |
| rdata | output | 8 | Read data, registered |
| rd_valid | output | 1 | rdata is valid this cycle |
| mem_m | output | 7 | Memory synthesizer M |
| mem_n | output | 5 | Memory synthesizer N |
| mem_r | output | 3 | Memory synthesizer R |
| vid_m | output | 7 | Video synthesizer M |
| vid_n | output | 5 | Video synthesizer N |
| vid_r | output | 3 | Video synthesizer R |
| pix_khz | output | 24 | Reported pixel clock in kHz |

## Verification
The lock is tried in both directions. Writes issued while locked must leave registers that are later read as zero. A relock after programming must hide the values and then reveal them unchanged. Locked reads cover both sides of the 0x1B boundary, so a wrong threshold or a wrong placeholder is caught. The clock report is checked for each of the four select values, with the halving bit clear and set. It is also checked with two synthesizer settings, one using a non-zero R and one using the maximum M with zero N and R. Together these separate a wrong divider order, a missing offset and a shift that is not applied.

// File: rtl/pxclk_pkg.sv
package pxclk_pkg;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;
  localparam int N_W    = 5;
  localparam int R_W    = 3;
  localparam int M_W    = 7;
  localparam int FREQ_W = 24;
  localparam int NUM_PLL = 2;
  localparam int MEM_PLL = 0;
  localparam int VID_PLL = 1;

  localparam logic [IDX_W-1:0] IDX_KEY      = 8'h08;
  localparam logic [IDX_W-1:0] IDX_PLL_BASE = 8'h10;
  localparam logic [IDX_W-1:0] IDX_CMD      = 8'h15;
  localparam logic [IDX_W-1:0] IDX_ECHO_MIN = 8'h1B;
  localparam logic [DATA_W-1:0] KEY_OPEN    = 8'h06;
  localparam int CMD_HALF_BIT = 4;

  localparam int unsigned REF_KHZ  = 14318;
  localparam int unsigned FIX0_KHZ = 25175;
  localparam int unsigned FIX1_KHZ = 28322;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } pll_t;

  // Synthesizer output in kHz: divide by (N+2) first, then shift by R.
  function automatic logic [FREQ_W-1:0] synth_khz(input pll_t p);
    logic [31:0] num;
    logic [31:0] den;
    logic [31:0] q;
    num = REF_KHZ * (32'(p.m) + 32'd2);
    den = 32'(p.n) + 32'd2;
    q   = num / den;
    q   = q >> p.r;
    return q[FREQ_W-1:0];
  endfunction

  function automatic logic [FREQ_W-1:0] pick_khz(input logic [1:0] sel, input pll_t vid,
                                                 input logic half);
    logic [FREQ_W-1:0] f;
    case (sel)
      2'd0:    f = FREQ_W'(FIX0_KHZ);
      2'd1:    f = FREQ_W'(FIX1_KHZ);
      default: f = synth_khz(vid);
    endcase
    return half ? (f >> 1) : f;
  endfunction
endpackage

// File: rtl/pxclk_key_gate.sv
module pxclk_key_gate
  import pxclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] key,
  output logic              unlocked,
  output logic              ext_idx,
  output logic              wr_ok
);
  logic key_hit;

  assign key_hit  = wr_en && (idx == IDX_KEY);
  assign unlocked = (key == KEY_OPEN);
  assign ext_idx  = (idx > IDX_KEY);
  assign wr_ok    = wr_en && (!ext_idx || unlocked);

  always_ff @(posedge clk) begin
    if (!rst_n)       key <= '0;
    else if (key_hit) key <= wdata;
  end

  // R4: the key register takes every write to its index.
  assert_key_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_KEY) |=> (key == $past(wdata)));
endmodule

// File: rtl/pxclk_param_bank.sv
module pxclk_param_bank
  import pxclk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_ok,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       wdata,
  output pll_t [NUM_PLL-1:0]      pll,
  output logic [DATA_W-1:0]       cmd
);
  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    localparam logic [IDX_W-1:0] NR_IDX = IDX_PLL_BASE + IDX_W'(2 * g);
    localparam logic [IDX_W-1:0] M_IDX  = NR_IDX + 8'd1;
    pll_t set_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        set_q <= '0;
      end else if (wr_ok && idx == NR_IDX) begin
        set_q.n <= wdata[N_W-1:0];
        set_q.r <= wdata[DATA_W-1:N_W];
      end else if (wr_ok && idx == M_IDX) begin
        set_q.m <= wdata[M_W-1:0];
      end
    end
    assign pll[g] = set_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      cmd <= '0;
    else if (wr_ok && idx == IDX_CMD) cmd <= wdata;
  end

  // R7: command byte loads exactly what was written.
  assert_cmd_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && idx == IDX_CMD) |=> (cmd == $past(wdata)));
endmodule

// File: rtl/pxclk_freq_calc.sv
module pxclk_freq_calc
  import pxclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        clk_sel,
  input  pll_t              vid,
  input  logic              half,
  output logic [FREQ_W-1:0] pix_khz
);
  always_ff @(posedge clk) begin
    if (!rst_n) pix_khz <= '0;
    else        pix_khz <= pick_khz(clk_sel, vid, half);
  end

  // R8: fixed oscillator rates.
  assert_fix0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd0 && !half) |=> (pix_khz == FREQ_W'(FIX0_KHZ)));
  assert_fix1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd1 && !half) |=> (pix_khz == FREQ_W'(FIX1_KHZ)));
  // R10: halving applies to the fixed rates too.
  assert_fix1_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd1 && half) |=> (pix_khz == FREQ_W'(FIX1_KHZ / 2)));
endmodule

// File: rtl/pxclk_cfg.sv
module pxclk_cfg
  import pxclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        idx,
  input  logic [7:0]        wdata,
  input  logic [1:0]        clk_sel,
  output logic [7:0]        rdata,
  output logic              rd_valid,
  output logic [6:0]        mem_m,
  output logic [4:0]        mem_n,
  output logic [2:0]        mem_r,
  output logic [6:0]        vid_m,
  output logic [4:0]        vid_n,
  output logic [2:0]        vid_r,
  output logic [23:0]       pix_khz
);
  logic [DATA_W-1:0]  key;
  logic               unlocked;
  logic               ext_idx;
  logic               wr_ok;
  pll_t [NUM_PLL-1:0] pll;
  logic [DATA_W-1:0]  cmd;
  logic [DATA_W-1:0]  rd_next;

  pxclk_key_gate u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(wdata),
    .key(key), .unlocked(unlocked), .ext_idx(ext_idx), .wr_ok(wr_ok)
  );

  pxclk_param_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .idx(idx), .wdata(wdata),
    .pll(pll), .cmd(cmd)
  );

  pxclk_freq_calc u_freq (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .vid(pll[VID_PLL]),
    .half(cmd[CMD_HALF_BIT]), .pix_khz(pix_khz)
  );

  always_comb begin
    rd_next = '0;
    if (ext_idx && !unlocked) begin
      rd_next = (idx < IDX_ECHO_MIN) ? '0 : idx;
    end else begin
      case (idx)
        IDX_KEY:            rd_next = key;
        IDX_PLL_BASE:       rd_next = {pll[MEM_PLL].r, pll[MEM_PLL].n};
        IDX_PLL_BASE + 8'd1: rd_next = {1'b0, pll[MEM_PLL].m};
        IDX_PLL_BASE + 8'd2: rd_next = {pll[VID_PLL].r, pll[VID_PLL].n};
        IDX_PLL_BASE + 8'd3: rd_next = {1'b0, pll[VID_PLL].m};
        IDX_CMD:            rd_next = cmd;
        default:            rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end

  assign mem_m = pll[MEM_PLL].m;
  assign mem_n = pll[MEM_PLL].n;
  assign mem_r = pll[MEM_PLL].r;
  assign vid_m = pll[VID_PLL].m;
  assign vid_n = pll[VID_PLL].n;
  assign vid_r = pll[VID_PLL].r;

  // R2: a locked extended write leaves every parameter untouched.
  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ext_idx && !unlocked) |=> ($stable(pll) && $stable(cmd)));
  // R3: locked extended reads never expose register content.
  assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ext_idx && !unlocked && idx < IDX_ECHO_MIN) |=> (rdata == 8'h00));
  // R12: read strobe is answered exactly one cycle later.
  assert_rd_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/pxclk_cfg_bench.sv
`timescale 1ns/1ps
module pxclk_cfg_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] idx = 0, wdata = 0;
  logic [1:0] clk_sel = 0;
  logic [7:0] rdata;
  logic rd_valid;
  logic [6:0] mem_m, vid_m;
  logic [4:0] mem_n, vid_n;
  logic [2:0] mem_r, vid_r;
  logic [23:0] pix_khz;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  pxclk_cfg u_pxclk_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx), .wdata(wdata),
    .clk_sel(clk_sel), .rdata(rdata), .rd_valid(rd_valid),
    .mem_m(mem_m), .mem_n(mem_n), .mem_r(mem_r),
    .vid_m(vid_m), .vid_n(vid_n), .vid_r(vid_r), .pix_khz(pix_khz)
  );

  // Expected rate restated as one combined division.
  function automatic int ref_khz(int m, int n, int r, bit half, int sel);
    longint f;
    if (sel == 0)      f = 25175;
    else if (sel == 1) f = 28322;
    else               f = (64'd14318 * (m + 2)) / ((n + 2) * (64'd1 << r));
    if (half) f = f / 2;
    return int'(f);
  endfunction

  task automatic check(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; idx = i; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] i, input logic [7:0] exp, input string req);
    @(posedge clk); #1;
    rd_en = 1; idx = i;
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic pix(input logic [1:0] s, input int exp, input string req);
    @(posedge clk); #1;
    clk_sel = s;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(req, pix_khz, exp);
  endtask

  // Monitor: pops one expected byte for each valid read.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected rd_valid", 1, 0);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R12 idle rd_valid", rd_valid, 0);
    // R1: reset contents, key readable while locked
    rd(8'h08, 8'h00, "R1 key after reset");
    check("R1 vid_m after reset", vid_m, 0);
    // R3: locked placeholders on both sides of 0x1B
    rd(8'h10, 8'h00, "R3 locked 0x10");
    rd(8'h1A, 8'h00, "R3 locked 0x1A");
    rd(8'h1B, 8'h1B, "R3 locked 0x1B");
    rd(8'h40, 8'h40, "R3 locked 0x40");
    rd(8'hFF, 8'hFF, "R3 locked 0xFF");
    // R2: locked writes dropped
    wr(8'h12, 8'hAB);
    wr(8'h15, 8'h10);
    wr(8'h08, 8'h06);
    rd(8'h08, 8'h06, "R4 key readback");
    rd(8'h12, 8'h00, "R2 locked write to 0x12 dropped");
    rd(8'h15, 8'h00, "R2 locked write to 0x15 dropped");
    // R5 / R6: field layout
    wr(8'h10, 8'hE5);
    rd(8'h10, 8'hE5, "R5 mem N/R readback");
    @(negedge clk);
    check("R5 mem_n port", mem_n, 5);
    check("R5 mem_r port", mem_r, 7);
    wr(8'h11, 8'hFF);
    rd(8'h11, 8'h7F, "R6 mem M bit7 dropped");
    wr(8'h12, 8'h2A);
    wr(8'h13, 8'h50);
    rd(8'h12, 8'h2A, "R5 vid N/R readback");
    rd(8'h13, 8'h50, "R6 vid M readback");
    @(negedge clk);
    check("R5 vid_n port", vid_n, 10);
    check("R5 vid_r port", vid_r, 1);
    // R11: empty indexes while unlocked
    rd(8'h09, 8'h00, "R11 unlocked 0x09");
    rd(8'h05, 8'h00, "R11 unlocked 0x05");
    rd(8'h1B, 8'h00, "R11 unlocked 0x1B");
    // R7: command byte
    wr(8'h15, 8'hFF);
    rd(8'h15, 8'hFF, "R7 cmd readback");
    wr(8'h15, 8'h00);
    // R8 / R9
    pix(2'd0, ref_khz(0, 0, 0, 0, 0), "R8 sel0");
    pix(2'd1, ref_khz(0, 0, 0, 0, 1), "R8 sel1");
    pix(2'd2, ref_khz(8'h50, 10, 1, 0, 2), "R9 sel2");
    pix(2'd3, ref_khz(8'h50, 10, 1, 0, 3), "R9 sel3");
    // R10: halving on all selects
    wr(8'h15, 8'h10);
    pix(2'd2, ref_khz(8'h50, 10, 1, 1, 2), "R10 sel2 halved");
    pix(2'd0, ref_khz(0, 0, 0, 1, 0), "R10 sel0 halved");
    pix(2'd1, ref_khz(0, 0, 0, 1, 1), "R10 sel1 halved");
    wr(8'h15, 8'h00);
    wr(8'h12, 8'h00);
    wr(8'h13, 8'h7F);
    pix(2'd2, ref_khz(127, 0, 0, 0, 2), "R9 max M");
    wr(8'h12, 8'h2A);
    // R2: relock hides and protects, unlock reveals unchanged
    wr(8'h08, 8'h07);
    rd(8'h12, 8'h00, "R3 relocked 0x12");
    wr(8'h12, 8'h55);
    wr(8'h08, 8'h06);
    rd(8'h12, 8'h2A, "R2 relocked write dropped");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 queue drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule